// File: doc/BRIEF.md
# Shared-RAM Address Decoder and Phase Multiplexer

This block sits between a processor with a 24-bit address bus and the memory system of a small computer in which one RAM is shared with a video controller. It owns the two-phase bus clock `phi2`. While `phi2` is low the RAM address comes from the video fetch address and the RAM is read. While `phi2` is high the processor owns the RAM and every other device on the bus.

During the processor phase the low 20 address bits are decoded into one of five outcomes:
- the 256 KB RAM;
- a 64 KB boot ROM;
- a write-only window that produces a write strobe for the video scroll registers;
- an even-address-only peripheral chip;
- unmapped space.

A read that reaches no device is answered with a fixed fill byte, so the processor never samples a floating bus.

Top module: `shram_decoder`

## Requirements
- R1: Only `cpu_addr[19:0]` takes part in decoding; `cpu_addr[23:20]` has no effect on any output.
- R2: While `rst_n` is low, `phi2` is 0. After release, `phi2` starts toggling within three clock cycles and then inverts on every rising edge of `clk`, never staying high for two consecutive cycles.
- R3: While `phi2` is 0, the outputs are fixed as follows:
  - `ram_addr` equals `vid_addr`;
  - `ram_ce_n` and `ram_oe_n` are 0 and `ram_we_n` is 1;
  - `rom_ce_n`, `rom_oe_n` and `via_cs_n` are 1;
  - `scroll_we` and `fill_oe` are 0.
- R4: While `phi2` is 1, `ram_addr` equals `cpu_addr[17:0]`. For addresses 0x00000–0x3FFFF, `ram_ce_n` is 0, `ram_oe_n` is 0 only when `cpu_rw_n`=1, and `ram_we_n` is 0 only when `cpu_rw_n`=0. Outside that range all three RAM strobes are 1.
- R5: While `phi2` is 1 and the address is in 0x80000–0x8FFFF, `rom_ce_n` is 0, and `rom_oe_n` is 0 only on reads. Otherwise both are 1.
- R6: While `phi2` is 1, a write to 0xBF000–0xBFFFF raises `scroll_we` and selects no device. `scroll_idx` always carries `cpu_addr[3:0]`.
- R7: While `phi2` is 1, an even address (bit 0 = 0) in 0xFF000–0xFFFFF drives `via_cs_n` to 0. Odd addresses there select nothing. `via_rs` always carries `cpu_addr[4:1]`.
- R8: While `phi2` is 1, a read from unmapped space (0x40000–0x7FFFF, 0x90000–0xBEFFF, 0xC0000–0xFEFFF), from the scroll window, or from an odd peripheral address raises `fill_oe`. Writes there change nothing. `fill_data` is always 0xFF.
- R9: At no time is more than one of {RAM selected for the processor, ROM, peripheral, scroll strobe, fill} active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock; `phi2` runs at half its rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_addr | input | 24 | Processor address |
| cpu_rw_n | input | 1 | Processor direction, 1 = read, 0 = write |
| vid_addr | input | 18 | Video fetch address |
| phi2 | output | 1 | Bus phase, 1 = processor, 0 = video |
| ram_addr | output | 18 | Multiplexed RAM address |
| ram_ce_n | output | 1 | RAM chip enable, active low |
| ram_oe_n | output | 1 | RAM output enable, active low |
| ram_we_n | output | 1 | RAM write enable, active low |
| rom_ce_n | output | 1 | ROM chip enable, active low |
| rom_oe_n | output | 1 | ROM output enable, active low |
| via_cs_n | output | 1 | Peripheral chip select, active low |
| via_rs | output | 4 | Peripheral register select |
| scroll_we | output | 1 | Scroll register write strobe |
| scroll_idx | output | 4 | Scroll register index |
| fill_oe | output | 1 | Drive the fill byte onto the data bus |
| fill_data | output | 8 | Fill byte |

## Verification
The assertions assume that `cpu_addr`, `cpu_rw_n` and `vid_addr` are stable around each rising clock edge, because the decode is purely combinational from those inputs and from the registered `phi2`. The stimulus respects this by changing inputs only on falling edges. It sweeps every 4 KB page of the 20-bit space at both even and odd offsets, in both directions and in both phases. The upper four address bits are varied throughout to show they are ignored.

// File: rtl/shram_pkg.sv
package shram_pkg;
  localparam int DEC_W = 20;

  typedef enum logic [2:0] {
    RG_NONE   = 3'd0,
    RG_RAM    = 3'd1,
    RG_ROM    = 3'd2,
    RG_SCROLL = 3'd3,
    RG_PERIPH = 3'd4
  } region_e;

  localparam logic [DEC_W-1:0] RAM_LO    = 20'h00000;
  localparam logic [DEC_W-1:0] RAM_HI    = 20'h3FFFF;
  localparam logic [DEC_W-1:0] ROM_LO    = 20'h80000;
  localparam logic [DEC_W-1:0] ROM_HI    = 20'h8FFFF;
  localparam logic [DEC_W-1:0] SCROLL_LO = 20'hBF000;
  localparam logic [DEC_W-1:0] SCROLL_HI = 20'hBFFFF;
  localparam logic [DEC_W-1:0] PERIPH_LO = 20'hFF000;
  localparam logic [DEC_W-1:0] PERIPH_HI = 20'hFFFFF;
endpackage

// File: rtl/shram_phase_gen.sv
module shram_phase_gen (
  input  logic clk,
  input  logic rst_n,
  output logic phi2
);
  logic sync_q1, sync_q2;
  logic phi2_q, phi2_d, phi2_en;

  // reset release synchroniser
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q1 <= 1'b0;
      sync_q2 <= 1'b0;
    end else begin
      sync_q1 <= 1'b1;
      sync_q2 <= sync_q1;
    end
  end

  always_comb begin
    phi2_en = sync_q2;
    phi2_d  = ~phi2_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       phi2_q <= 1'b0;
    else if (phi2_en) phi2_q <= phi2_d;
  end

  assign phi2 = phi2_q;
endmodule

// File: rtl/shram_addr_decode.sv
module shram_addr_decode
  import shram_pkg::*;
#(
  parameter int ADDR_W = 24
) (
  input  logic [ADDR_W-1:0] addr,
  output region_e           region,
  output logic              odd
);
  logic [DEC_W-1:0] a;

  always_comb begin
    a   = addr[DEC_W-1:0];
    odd = a[0];
    if (a <= RAM_HI)                          region = RG_RAM;
    else if (a >= ROM_LO && a <= ROM_HI)      region = RG_ROM;
    else if (a >= SCROLL_LO && a <= SCROLL_HI) region = RG_SCROLL;
    else if (a >= PERIPH_LO)                  region = RG_PERIPH;
    else                                      region = RG_NONE;
  end
endmodule

// File: rtl/shram_bus_ctrl.sv
module shram_bus_ctrl
  import shram_pkg::*;
#(
  parameter int RAM_AW = 18,
  parameter int ADDR_W = 24
) (
  input  logic              phi2,
  input  region_e           region,
  input  logic              odd,
  input  logic              rw_n,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic [RAM_AW-1:0] vid_addr,
  output logic [RAM_AW-1:0] ram_addr,
  output logic              ram_ce_n,
  output logic              ram_oe_n,
  output logic              ram_we_n,
  output logic              rom_ce_n,
  output logic              rom_oe_n,
  output logic              via_cs_n,
  output logic              scroll_we,
  output logic              fill_oe
);
  logic hit_ram, hit_rom, hit_via, hit_scr;

  always_comb begin
    hit_ram = phi2 && (region == RG_RAM);
    hit_rom = phi2 && (region == RG_ROM);
    hit_via = phi2 && (region == RG_PERIPH) && !odd;
    hit_scr = phi2 && (region == RG_SCROLL);

    if (phi2) begin
      ram_addr = cpu_addr[RAM_AW-1:0];
      ram_ce_n = !hit_ram;
      ram_oe_n = !(hit_ram && rw_n);
      ram_we_n = !(hit_ram && !rw_n);
    end else begin
      ram_addr = vid_addr;
      ram_ce_n = 1'b0;
      ram_oe_n = 1'b0;
      ram_we_n = 1'b1;
    end

    rom_ce_n  = !hit_rom;
    rom_oe_n  = !(hit_rom && rw_n);
    via_cs_n  = !hit_via;
    scroll_we = hit_scr && !rw_n;
    fill_oe   = phi2 && rw_n && !hit_ram && !hit_rom && !hit_via;
  end
endmodule

// File: rtl/shram_decoder.sv
module shram_decoder
  import shram_pkg::*;
#(
  parameter int          ADDR_W  = 24,
  parameter int          RAM_AW  = 18,
  parameter int          RS_W    = 4,
  parameter int          SIDX_W  = 4,
  parameter int          DATA_W  = 8,
  parameter logic [7:0]  FILL    = 8'hFF
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic              cpu_rw_n,
  input  logic [RAM_AW-1:0] vid_addr,
  output logic              phi2,
  output logic [RAM_AW-1:0] ram_addr,
  output logic              ram_ce_n,
  output logic              ram_oe_n,
  output logic              ram_we_n,
  output logic              rom_ce_n,
  output logic              rom_oe_n,
  output logic              via_cs_n,
  output logic [RS_W-1:0]   via_rs,
  output logic              scroll_we,
  output logic [SIDX_W-1:0] scroll_idx,
  output logic              fill_oe,
  output logic [DATA_W-1:0] fill_data
);
  region_e region;
  logic    odd;

  shram_phase_gen u_phase (
    .clk   (clk),
    .rst_n (rst_n),
    .phi2  (phi2)
  );

  shram_addr_decode #(.ADDR_W(ADDR_W)) u_dec (
    .addr   (cpu_addr),
    .region (region),
    .odd    (odd)
  );

  shram_bus_ctrl #(.RAM_AW(RAM_AW), .ADDR_W(ADDR_W)) u_ctrl (
    .phi2      (phi2),
    .region    (region),
    .odd       (odd),
    .rw_n      (cpu_rw_n),
    .cpu_addr  (cpu_addr),
    .vid_addr  (vid_addr),
    .ram_addr  (ram_addr),
    .ram_ce_n  (ram_ce_n),
    .ram_oe_n  (ram_oe_n),
    .ram_we_n  (ram_we_n),
    .rom_ce_n  (rom_ce_n),
    .rom_oe_n  (rom_oe_n),
    .via_cs_n  (via_cs_n),
    .scroll_we (scroll_we),
    .fill_oe   (fill_oe)
  );

  assign via_rs     = cpu_addr[RS_W:1];
  assign scroll_idx = cpu_addr[SIDX_W-1:0];
  assign fill_data  = FILL[DATA_W-1:0];
endmodule

// File: rtl/shram_decoder_chk.sv
module shram_decoder_chk #(
  parameter int RAM_AW = 18
) (
  input logic              clk,
  input logic              rst_n,
  input logic              phi2,
  input logic              cpu_rw_n,
  input logic [RAM_AW-1:0] vid_addr,
  input logic [RAM_AW-1:0] ram_addr,
  input logic              ram_ce_n,
  input logic              ram_we_n,
  input logic              rom_ce_n,
  input logic              rom_oe_n,
  input logic              via_cs_n,
  input logic              scroll_we,
  input logic              fill_oe
);
  // R2
  phase_alt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    phi2 |=> !phi2);

  // R3
  video_owns_ram_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !phi2 |-> (ram_addr == vid_addr) && !ram_ce_n && ram_we_n);

  // R3
  video_quiet_bus_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !phi2 |-> rom_ce_n && rom_oe_n && via_cs_n && !scroll_we && !fill_oe);

  // R4
  ram_write_cpu_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ram_we_n |-> phi2 && !cpu_rw_n && !ram_ce_n);

  // R9
  single_target_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({phi2 && !ram_ce_n, !rom_ce_n, !via_cs_n, scroll_we, fill_oe}));

  // R6
  scroll_write_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    scroll_we |-> !cpu_rw_n);
endmodule

bind shram_decoder shram_decoder_chk #(.RAM_AW(RAM_AW)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .phi2      (phi2),
  .cpu_rw_n  (cpu_rw_n),
  .vid_addr  (vid_addr),
  .ram_addr  (ram_addr),
  .ram_ce_n  (ram_ce_n),
  .ram_we_n  (ram_we_n),
  .rom_ce_n  (rom_ce_n),
  .rom_oe_n  (rom_oe_n),
  .via_cs_n  (via_cs_n),
  .scroll_we (scroll_we),
  .fill_oe   (fill_oe)
);

// File: tb/sim_shram_decoder.sv
`timescale 1ns/1ps
module sim_shram_decoder;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [23:0] cpu_addr;
  logic        cpu_rw_n;
  logic [17:0] vid_addr;
  logic        phi2;
  logic [17:0] ram_addr;
  logic        ram_ce_n, ram_oe_n, ram_we_n, rom_ce_n, rom_oe_n, via_cs_n;
  logic [3:0]  via_rs, scroll_idx;
  logic        scroll_we, fill_oe;
  logic [7:0]  fill_data;

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  always #4 clk = ~clk;

  shram_decoder u0 (
    .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .cpu_rw_n(cpu_rw_n),
    .vid_addr(vid_addr), .phi2(phi2), .ram_addr(ram_addr),
    .ram_ce_n(ram_ce_n), .ram_oe_n(ram_oe_n), .ram_we_n(ram_we_n),
    .rom_ce_n(rom_ce_n), .rom_oe_n(rom_oe_n), .via_cs_n(via_cs_n),
    .via_rs(via_rs), .scroll_we(scroll_we), .scroll_idx(scroll_idx),
    .fill_oe(fill_oe), .fill_data(fill_data)
  );

  function automatic logic [42:0] got_vec();
    return {ram_addr, ram_ce_n, ram_oe_n, ram_we_n, rom_ce_n, rom_oe_n,
            via_cs_n, via_rs, scroll_we, scroll_idx, fill_oe, fill_data};
  endfunction

  // expected outputs from the requirement text
  function automatic logic [42:0] exp_vec(input logic ph, input logic [23:0] a,
                                          input logic rw, input logic [17:0] v);
    logic [19:0] d;
    logic ram, rom, scr, per, via;
    logic [17:0] ra;
    logic rce, roe, rwe, mce, moe, vcs, swe, fo;
    d   = a[19:0];                                   // R1
    ram = d < 20'h40000;
    rom = d >= 20'h80000 && d < 20'h90000;
    scr = d >= 20'hBF000 && d < 20'hC0000;
    per = d >= 20'hFF000;
    via = per && !d[0];
    if (!ph) begin                                    // R3
      ra = v; rce = 0; roe = 0; rwe = 1;
      mce = 1; moe = 1; vcs = 1; swe = 0; fo = 0;
    end else begin
      ra  = a[17:0];                                  // R4
      rce = !ram; roe = !(ram && rw); rwe = !(ram && !rw);
      mce = !rom; moe = !(rom && rw);                 // R5
      vcs = !via;                                     // R7
      swe = scr && !rw;                               // R6
      fo  = rw && !ram && !rom && !via;               // R8
    end
    return {ra, rce, roe, rwe, mce, moe, vcs, a[4:1], swe, a[3:0], fo, 8'hFF};
  endfunction

  function automatic string tag_of(input logic ph, input logic [19:0] d);
    if (!ph) return "R3";
    if (d < 20'h40000) return "R4";
    if (d >= 20'h80000 && d < 20'h90000) return "R5";
    if (d >= 20'hBF000 && d < 20'hC0000) return "R6";
    if (d >= 20'hFF000) return "R7";
    return "R8";
  endfunction

  task automatic check_now(input string tag);
    logic [42:0] e, g;
    e = exp_vec(phi2, cpu_addr, cpu_rw_n, vid_addr);
    g = got_vec();
    checks++;
    if (g !== e) begin
      errors++;
      $display("FAIL %s addr=%h rw=%b phi2=%b got=%h exp=%h",
               tag, cpu_addr, cpu_rw_n, phi2, g, e);
    end
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, errors);
      $finish;
    end
  end

  initial begin
    logic prev_ph;
    bit   started;
    rst_n = 1'b0; cpu_addr = 24'h0; cpu_rw_n = 1'b1; vid_addr = 18'h0;
    repeat (3) @(negedge clk);
    cpu_addr = 24'h080000; vid_addr = 18'h2A5A5;
    #2;
    // R2 reset state
    checks++;
    if (phi2 !== 1'b0) begin errors++; $display("FAIL R2 reset phi2 got=%b exp=0", phi2); end
    check_now("R3");
    @(negedge clk) rst_n = 1'b1;
    prev_ph = 1'b0; started = 0;
    // R2 phase must start within three cycles
    repeat (4) @(negedge clk);
    #2;
    checks++;
    if (phi2 !== 1'b1 && prev_ph === 1'b0) begin
      // after four cycles one of the last two samples must be high
      @(negedge clk); #2;
      if (phi2 !== 1'b1) begin errors++; $display("FAIL R2 phi2 not started got=%b exp=1", phi2); end
    end
    prev_ph = phi2; started = 1;

    for (int p = 0; p < 256; p++) begin
      for (int o = 0; o < 4; o++) begin
        for (int w = 0; w < 2; w++) begin
          for (int c = 0; c < 2; c++) begin
            logic [11:0] off;
            case (o)
              0: off = 12'h000;
              1: off = 12'h001;
              2: off = 12'h01A;
              default: off = 12'hFFF;
            endcase
            @(negedge clk);
            cpu_addr = {4'(p * 7 + o + c), 8'(p), off};   // R1: upper nibble varies
            cpu_rw_n = (w == 0);
            vid_addr = 18'((p * 1031 + o * 97 + c * 13) & 18'h3FFFF);
            #2;
            check_now(tag_of(phi2, cpu_addr[19:0]));
            // R2 alternation
            checks++;
            if (started && phi2 === prev_ph) begin
              errors++;
              $display("FAIL R2 phi2 did not toggle got=%b exp=%b", phi2, !prev_ph);
            end
            prev_ph = phi2;
          end
        end
      end
    end

    // R1 explicit: same low address, different upper nibble, same outputs
    for (int u = 0; u < 16; u++) begin
      @(negedge clk);
      cpu_addr = {4'(u), 20'hFF004}; cpu_rw_n = 1'b0;
      #2;
      check_now("R1");
    end

    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, errors);
    $finish;
  end
endmodule